// File: doc/BRIEF.md
# Byte Memory Unit with Boot-Copy Mode

This block is the memory of a small 8-bit CPU built around a single shared data bus. It holds an address register that loads from the bus, a 256-byte RAM, and a 256-byte ROM whose contents are fixed when the design is elaborated. The bidirectional bus is split into a bus-in port, a bus-out port and a drive enable. Two active-low requests, one for output and one for write, are decoded into the RAM selects, the RAM output enable, and the direction and enable of the bus transceiver.

A mode input selects between run mode and boot-copy mode. In run mode every access goes to RAM. In boot-copy mode a read returns the ROM byte at the latched address, while a write still stores into RAM at that address. A short loader program can therefore read each ROM byte and write it back to the same address, which copies the image into RAM. After that the CPU switches to run mode and executes from RAM.

Reads are combinational from the latched address. Address loads and RAM writes take effect on the rising clock edge.

Top module: `memu_top`

## Requirements
- R1: After reset, the address register holds 0 and, with both requests inactive, `bus_oe` is low.
- R2: On a rising edge with `mar_ld` high, the address register takes the value of `bus_in`. Otherwise it keeps its value.
- R3: `bus_oe` is high only when `out_n` is 0 and `wr_n` is 1. When both requests are low, the write wins and the bus is not driven.
- R4: In run mode (`boot_mode`=0), a read returns the RAM byte at the latched address, and the ROM is never selected.
- R5: In boot-copy mode (`boot_mode`=1), a read returns the ROM byte at the latched address. For address a, that byte is ((29*a + 91) mod 256) XOR (a with its two nibbles swapped).
- R6: On a rising edge with `wr_n`=0, `bus_in` is stored into RAM at the latched address, in either mode. The ROM contents never change.
- R7: RAM contents change only on a clock edge with `wr_n`=0. Cycles with `wr_n`=1 leave RAM unchanged, even when `out_n` is low or `bus_in` moves.
- R8: When `mar_ld` and `wr_n`=0 occur on the same edge, the write uses the address held before that edge, and the register then takes the new value.
- R9: Reading each ROM byte and writing it back in boot-copy mode, then switching to run mode, leaves every RAM location equal to the ROM image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; address loads and RAM writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the address register |
| bus_in | input | 8 | Value present on the shared bus |
| bus_out | output | 8 | Byte this block offers to the bus |
| bus_oe | output | 1 | High when the block drives the bus |
| out_n | input | 1 | Active-low output request |
| wr_n | input | 1 | Active-low write request |
| mar_ld | input | 1 | Load the address register from `bus_in` |
| boot_mode | input | 1 | 1 = boot-copy mode, 0 = run mode |

## Verification
The bench goes after the paths where a read in one mode and a write in the other could meet the wrong memory. If boot-copy reads were served from RAM, the copy would return unwritten data and would not match the ROM image. If boot-copy writes landed nowhere, or in ROM, the run-mode sweep would find mismatches. It asserts both requests together and checks that the drive stays off, since a design that let the output win would fight the bus during a write. It also loads the address register and writes on the same edge: a design that used the new address would corrupt the neighbouring byte and leave the intended one stale.

// File: rtl/memu_pkg.sv
package memu_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  // decoded control set for one cycle
  typedef struct packed {
    logic ram_sel;   // RAM chip selected
    logic rom_sel;   // ROM chip selected
    logic ram_oe;    // RAM output enabled
    logic to_bus;    // transceiver points toward the bus
    logic xcvr_en;   // transceiver enabled
    logic drive_en;  // block drives bus_out
    logic ram_we;    // RAM write strobe request
  } memu_ctl_t;

  // ROM image: scrambled arithmetic pattern, one byte per address
  function automatic logic [DATA_W-1:0] rom_byte(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] lin;
    logic [DATA_W-1:0] swp;
    lin = DATA_W'(a) * DATA_W'(29) + DATA_W'(91);
    swp = DATA_W'({a[3:0], a[ADDR_W-1:4]});
    return lin ^ swp;
  endfunction

endpackage

// File: rtl/memu_mar.sv
module memu_mar #(
  parameter int AW = memu_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load) q <= d;
  end

  AST_MAR_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d))); // R2
  AST_MAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R2

endmodule

// File: rtl/memu_ctrl.sv
module memu_ctrl (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 out_n,
  input  logic                 wr_n,
  input  logic                 boot,
  output memu_pkg::memu_ctl_t  ctl
);

  logic wr_req;
  logic out_req;

  assign wr_req  = !wr_n;
  assign out_req = !out_n;

  always_comb begin
    ctl.ram_oe   = !wr_req;
    ctl.to_bus   = ctl.ram_oe;
    ctl.xcvr_en  = out_req || wr_req;
    ctl.drive_en = ctl.xcvr_en && ctl.to_bus;
    // run mode: RAM permanently selected; boot mode: RAM only on writes
    ctl.ram_sel  = boot ? wr_req : 1'b1;
    ctl.rom_sel  = boot && ctl.ram_oe;
    ctl.ram_we   = wr_req && ctl.ram_sel;
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !ctl.drive_en); // R3
  AST_ROM_ONLY_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.rom_sel |-> boot); // R4
  AST_ONE_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
    boot |-> $onehot({ctl.ram_sel, ctl.rom_sel})); // R5
  AST_WRITE_REACHES_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (ctl.ram_we && !ctl.rom_sel)); // R6

endmodule

// File: rtl/memu_ram.sv
module memu_ram #(
  parameter int AW = memu_pkg::ADDR_W,
  parameter int DW = memu_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

  AST_RAM_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(addr)] == $past(wdata))); // R6
  AST_RAM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !$isunknown(rdata)) |=> (mem[$past(addr)] == $past(rdata))); // R7

endmodule

// File: rtl/memu_rom.sv
module memu_rom #(
  parameter int AW = memu_pkg::ADDR_W,
  parameter int DW = memu_pkg::DATA_W
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] image [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_img
    assign image[i] = DW'(memu_pkg::rom_byte(memu_pkg::ADDR_W'(i)));
  end

  assign rdata = image[addr];

endmodule

// File: rtl/memu_top.sv
module memu_top (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_in,
  output logic [7:0] bus_out,
  output logic       bus_oe,
  input  logic       out_n,
  input  logic       wr_n,
  input  logic       mar_ld,
  input  logic       boot_mode
);

  import memu_pkg::*;

  memu_ctl_t         ctl;
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] rom_q;
  logic              ram_write;

  memu_mar #(.AW(ADDR_W)) u_mar (
    .clk(clk), .rst_n(rst_n), .load(mar_ld), .d(bus_in[ADDR_W-1:0]), .q(mar_q)
  );

  memu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .out_n(out_n), .wr_n(wr_n),
    .boot(boot_mode), .ctl(ctl)
  );

  // write strobe qualified by the clock edge inside the RAM
  assign ram_write = ctl.ram_we && !ctl.to_bus;

  memu_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_write), .addr(mar_q),
    .wdata(bus_in), .rdata(ram_q)
  );

  memu_rom #(.AW(ADDR_W), .DW(DATA_W)) u_rom (
    .addr(mar_q), .rdata(rom_q)
  );

  assign bus_out = ctl.rom_sel ? rom_q : ram_q;
  assign bus_oe  = ctl.drive_en;

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_n && wr_n) |-> !bus_oe); // R3
  AST_BOOT_READS_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_mode && wr_n) |-> (bus_out == rom_byte(mar_q))); // R5
  AST_RUN_READS_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_mode && !$isunknown(ram_q)) |-> (bus_out == ram_q)); // R4
  AST_LOAD_WRITE_OLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mar_ld && !wr_n) |=> (mar_q == $past(bus_in))); // R8

endmodule

// File: tb/sim_memu_top.sv
module sim_memu_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out;
  logic       bus_oe;
  logic       out_n = 1'b1;
  logic       wr_n = 1'b1;
  logic       mar_ld = 1'b0;
  logic       boot_mode = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] data;
    logic       oe;
    bit         chk_data;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  always #5 clk = ~clk;

  memu_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .out_n(out_n), .wr_n(wr_n), .mar_ld(mar_ld),
    .boot_mode(boot_mode)
  );

  // independent restatement of the ROM image (R5)
  function automatic logic [7:0] rom_ref(input int a);
    int lin;
    int swp;
    lin = (a * 29 + 91) % 256;
    swp = (a % 16) * 16 + (a / 16);
    return 8'(lin) ^ 8'(swp);
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // monitor: pops expectations at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check({e.tag, " bus_oe"}, int'(bus_oe), int'(e.oe));
      if (e.chk_data) check({e.tag, " bus_out"}, int'(bus_out), int'(e.data));
    end
  end

  task automatic load_mar(input logic [7:0] a);
    @(posedge clk); #1;
    mar_ld = 1'b1; bus_in = a;
    @(posedge clk); #1;
    mar_ld = 1'b0; bus_in = 8'h00;
  endtask

  task automatic rd(input logic [7:0] exp, input string tag, output logic [7:0] got);
    exp_t e;
    @(posedge clk); #1;
    out_n = 1'b0;
    e.data = exp; e.oe = 1'b1; e.chk_data = 1'b1; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    got = bus_out;
    @(posedge clk); #1;
    out_n = 1'b1;
  endtask

  // write with optional simultaneous output request (write must win, R3)
  task automatic wr(input logic [7:0] d, input bit with_out, input bit with_ld);
    exp_t e;
    @(posedge clk); #1;
    wr_n = 1'b0; bus_in = d;
    out_n = with_out ? 1'b0 : 1'b1;
    mar_ld = with_ld;
    e.data = 8'h00; e.oe = 1'b0; e.chk_data = 1'b0; e.tag = "R3";
    sb_q.push_back(e);
    @(posedge clk); #1;
    wr_n = 1'b1; out_n = 1'b1; mar_ld = 1'b0; bus_in = 8'h00;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle bus_oe", int'(bus_oe), 0);

    // R1: address register resets to 0, seen through a boot read
    boot_mode = 1'b1;
    rd(rom_ref(0), "R1", v);

    // R5: boot reads at several addresses
    load_mar(8'h3C); rd(rom_ref(8'h3C), "R5", v);
    load_mar(8'hFF); rd(rom_ref(8'hFF), "R5", v);

    // R9: boot copy of the whole image
    for (int a = 0; a < 256; a++) begin
      load_mar(8'(a));
      rd(rom_ref(a), "R9 boot read", v);
      wr(v, (a % 3) == 0, 1'b0);
    end

    // R6/R4: run-mode writes, then ROM unchanged in boot mode
    boot_mode = 1'b0;
    load_mar(8'h10); wr(8'hA5, 1'b0, 1'b0);
    rd(8'hA5, "R6 run write", v);
    rd(8'hA5, "R4 run read", v);
    boot_mode = 1'b1;
    rd(rom_ref(8'h10), "R6 rom kept", v);
    wr(8'h5A, 1'b1, 1'b0);
    boot_mode = 1'b0;
    rd(8'h5A, "R6 boot write", v);

    // R7: no write without the request
    load_mar(8'h20);
    @(posedge clk); #1;
    out_n = 1'b0; bus_in = 8'hEE;
    repeat (3) @(posedge clk);
    #1; out_n = 1'b1; bus_in = 8'h13;
    repeat (2) @(posedge clk);
    rd(rom_ref(8'h20), "R7 untouched", v);

    // R8: load and write on the same edge: data 0x07 goes to old address 0x30
    load_mar(8'h30);
    wr(8'h07, 1'b0, 1'b1);
    rd(rom_ref(8'h07), "R8 new address", v);
    load_mar(8'h30);
    rd(8'h07, "R8 old address", v);

    // R3: explicit idle check
    @(negedge clk);
    check("R3 idle", int'(bus_oe), 0);

    // R9: run-mode sweep against the image (0x10 and 0x30 rewritten above)
    for (int a = 0; a < 256; a++) begin
      logic [7:0] ex;
      ex = rom_ref(a);
      if (a == 8'h10) ex = 8'h5A;
      if (a == 8'h30) ex = 8'h07;
      load_mar(8'(a));
      rd(ex, "R9 run sweep", v);
    end

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule